// File: doc/BRIEF.md
# Digit-Pipelined Array Multiplier

This block multiplies two unsigned operands. It works on 4-bit digits, not on single bits. A grid of radix cells, one row for each digit of the second operand, forms the partial products. Each cell multiplies one digit of U by one digit of V and adds an incoming sum digit and an incoming carry digit. It passes the low result digit and the high result digit to the next row through pipeline registers. Each row retires one low-order product digit. A chain of digit-wide boundary adders, one stage for each digit, then resolves the remaining sum and carry digits into the high-order product digits. No stage adds anything wider than one digit plus a carry, so the clock period is set by the digit size and not by the operand width.

Operands travel down the pipeline together with the partial results. The second operand is consumed one digit per row, and the retired product digits move into the same shift word. A new operand pair can be presented on every clock. Each pair carries a valid flag, which follows the data and marks the full 32-bit product when it leaves the last stage.

Top module: `digit_array_mult`

## Requirements
- R1: With valid high, `out_w` equals the unsigned product `in_u * in_v` of the pair that was sampled together with that valid flag.
- R2: A pair sampled with `in_valid` high at rising edge n gives `out_valid` high right after rising edge n+7. A pair sampled with `in_valid` low gives `out_valid` low in that same slot.
- R3: Pairs applied on consecutive clocks with no idle cycle come out on consecutive clocks, each with its own correct product.
- R4: `out_valid` is low while `rst_n` is low. After reset is released it stays low until a valid pair has passed through all eight stages.
- R5: The largest operands, 0xFFFF times 0xFFFF, give 0xFFFE0001. The last boundary adder never produces a carry out of the top digit.
- R6: Pulling `rst_n` low while pairs are in flight discards them. None of them produces a valid output after reset is released, and pairs applied afterwards are multiplied correctly.
- R7: Carries move correctly across digit boundaries, both inside the cell grid and through the boundary adders. Examples: 0x1000 times 0x1000 gives 0x01000000, 0xFFFF times 0x0001 gives 0x0000FFFF, and a zero operand gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the valid pipeline |
| in_valid | input | 1 | Marks `in_u`/`in_v` as a pair to multiply this cycle |
| in_u | input | 16 | First operand, four 4-bit digits, unsigned |
| in_v | input | 16 | Second operand, four 4-bit digits, unsigned |
| out_valid | output | 1 | High when `out_w` holds a finished product |
| out_w | output | 32 | Product, eight 4-bit digits, unsigned |

## Verification
The bench targets operands that make every cell produce its largest value, for example all-ones digits. If a cell or boundary adder lost its high digit or final carry, these products would come out truncated or wrapped. It also uses single non-zero digits in the top positions. A product digit sent to the wrong slot of the shift word would show up as a shifted or reordered result. A random stream with random idle gaps tests the latency and the valid alignment: an off-by-one stage count or a valid flag that did not follow its data would produce misaligned pulses or products taken from a neighbouring pair. A reset applied while pairs are in flight checks that the valid pipeline is cleared rather than left holding stale pulses.

// File: rtl/digit_array_mult.sv
module digit_array_mult #(
  parameter int DIG  = 4,
  parameter int NDIG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DIG*NDIG-1:0]     in_u,
  input  logic [DIG*NDIG-1:0]     in_v,
  output logic                    out_valid,
  output logic [2*DIG*NDIG-1:0]   out_w
);
  localparam int NW  = DIG * NDIG;
  localparam int PW  = 2 * NW;
  localparam int NST = 2 * NDIG;
  localparam int CW  = 2 * DIG;
  localparam int DW1 = DIG + 1;

  logic [NST-1:0] vld_q;
  logic [NW-1:0]  u_q  [NDIG-1];
  logic [PW-1:0]  x_q  [NST];
  logic [NW-1:0]  s_q  [NST-1];
  logic [NW-1:0]  c_q  [NST-1];
  logic           cy_q [NDIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[NST-2:0], in_valid};
  end

  for (genvar t = 0; t < NDIG; t++) begin : g_row
    logic [NW-1:0] u_in, s_in, c_in, lo, hi;
    logic [PW-1:0] x_in;

    if (t == 0) begin : g_first
      assign u_in = in_u;
      assign x_in = {{NW{1'b0}}, in_v};
      assign s_in = '0;
      assign c_in = '0;
    end else begin : g_next
      assign u_in = u_q[t-1];
      assign x_in = x_q[t-1];
      assign s_in = s_q[t-1];
      assign c_in = c_q[t-1];
    end

    for (genvar j = 0; j < NDIG; j++) begin : g_cell
      logic [CW-1:0] acc;
      assign acc = CW'(u_in[j*DIG +: DIG]) * CW'(x_in[DIG-1:0])
                 + CW'(s_in[j*DIG +: DIG]) + CW'(c_in[j*DIG +: DIG]);
      assign lo[j*DIG +: DIG] = acc[DIG-1:0];
      assign hi[j*DIG +: DIG] = acc[CW-1:DIG];
    end

    always_ff @(posedge clk) begin
      x_q[t] <= {lo[DIG-1:0], x_in[PW-1:DIG]};
      s_q[t] <= {{DIG{1'b0}}, lo[NW-1:DIG]};
      c_q[t] <= hi;
    end

    if (t < NDIG-1) begin : g_fwd
      always_ff @(posedge clk) u_q[t] <= u_in;
    end
  end

  for (genvar k = 0; k < NDIG; k++) begin : g_fin
    localparam int T = NDIG + k;
    logic           cin_b;
    logic [DIG:0]   dsum;

    if (k == 0) begin : g_c0
      assign cin_b = 1'b0;
    end else begin : g_cn
      assign cin_b = cy_q[k-1];
    end

    assign dsum = DW1'(s_q[T-1][DIG-1:0]) + DW1'(c_q[T-1][DIG-1:0]) + DW1'(cin_b);

    always_ff @(posedge clk) begin
      x_q[T]  <= {dsum[DIG-1:0], x_q[T-1][PW-1:DIG]};
      cy_q[k] <= dsum[DIG];
    end

    if (k < NDIG-1) begin : g_pass
      always_ff @(posedge clk) begin
        s_q[T] <= s_q[T-1] >> DIG;
        c_q[T] <= c_q[T-1] >> DIG;
      end
    end
  end

  assign out_valid = vld_q[NST-1];
  assign out_w     = x_q[NST-1];
endmodule

// File: rtl/digit_array_mult_chk.sv
module digit_array_mult_chk #(
  parameter int DIG  = 4,
  parameter int NDIG = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [DIG*NDIG-1:0]   in_u,
  input logic [DIG*NDIG-1:0]   in_v,
  input logic                  out_valid,
  input logic [2*DIG*NDIG-1:0] out_w,
  input logic                  top_carry
);
  localparam int NW  = DIG * NDIG;
  localparam int PW  = 2 * NW;
  localparam int LAT = 2 * NDIG;
  localparam int WW  = $clog2(LAT + 1);
  localparam logic [WW-1:0] LATW = WW'(LAT);

  logic [LAT-1:0] vsh;
  logic [PW-1:0]  psh [LAT];
  logic [WW-1:0]  warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsh  <= '0;
      warm <= '0;
    end else begin
      vsh <= {vsh[LAT-2:0], in_valid};
      if (warm < LATW) warm <= warm + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    psh[0] <= PW'(in_u) * PW'(in_v);
    for (int i = 1; i < LAT; i++) psh[i] <= psh[i-1];
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_w == psh[LAT-1]);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LAT-1]);

  assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm < LATW) |-> !out_valid);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !top_carry);
endmodule

bind digit_array_mult digit_array_mult_chk #(.DIG(DIG), .NDIG(NDIG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_u      (in_u),
  .in_v      (in_v),
  .out_valid (out_valid),
  .out_w     (out_w),
  .top_carry (cy_q[NDIG-1])
);

// File: tb/digit_array_mult_tb.sv
module digit_array_mult_tb;
  localparam int PERIOD = 10;
  localparam int LAT    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_u = '0;
  logic [15:0] in_v = '0;
  logic        out_valid;
  logic [31:0] out_w;

  int    cnt = 0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  bit    ev [16];
  logic [31:0] ep [16];
  string et [16];

  digit_array_mult u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_u(in_u), .in_v(in_v), .out_valid(out_valid), .out_w(out_w)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    return {16'd0, a} * {16'd0, b};
  endfunction

  task automatic clear_ring(input string tag);
    for (int i = 0; i < 16; i++) begin
      ev[i] = 1'b0;
      ep[i] = '0;
      et[i] = tag;
    end
  endtask

  task automatic check_out();
    int idx;
    if (!rst_n) begin
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_err++;
        $display("FAIL R4/R6 out_valid in reset got %b exp 0", out_valid);
      end
    end else if (cnt >= LAT) begin
      idx = (cnt - LAT) % 16;
      n_chk++;
      if (out_valid !== ev[idx]) begin
        n_err++;
        $display("FAIL %s out_valid got %b exp %b (R2)", et[idx], out_valid, ev[idx]);
      end else if (ev[idx]) begin
        n_chk++;
        if (out_w !== ep[idx]) begin
          n_err++;
          $display("FAIL %s product got %h exp %h (R1)", et[idx], out_w, ep[idx]);
        end
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b, input string tag);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_u = a;
    in_v = b;
    ev[cnt % 16] = v && rst_n;
    ep[cnt % 16] = ref_mul(a, b);
    et[cnt % 16] = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    clear_ring("R4");
    idle(3, "R4");
    rst_n = 1'b1;
    idle(12, "R4");

    step(1'b1, 16'h0000, 16'h0000, "R7");
    step(1'b1, 16'hFFFF, 16'hFFFF, "R5");
    step(1'b1, 16'hFFFF, 16'h0001, "R7");
    step(1'b1, 16'h0001, 16'hFFFF, "R7");
    step(1'b1, 16'h1000, 16'h1000, "R7");
    step(1'b1, 16'h0000, 16'hFFFF, "R7");
    step(1'b1, 16'h8000, 16'h0002, "R7");
    step(1'b1, 16'h0FFF, 16'hF000, "R7");
    step(1'b1, 16'h1234, 16'h5678, "R3");
    step(1'b1, 16'hF0F0, 16'h0F0F, "R3");
    step(1'b1, 16'hFFFF, 16'hFFFE, "R5");
    idle(LAT + 2, "R4");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom % 8 == 0) a = 16'hFFFF;
      if ($urandom % 8 == 0) b = 16'hFFFF;
      step(($urandom % 4) != 0, a, b, "R2");
    end
    idle(LAT + 2, "R2");

    for (int i = 0; i < 5; i++) step(1'b1, 16'($urandom), 16'($urandom), "R6");
    rst_n = 1'b0;
    in_valid = 1'b0;
    clear_ring("R6");
    idle(3, "R6");
    rst_n = 1'b1;
    idle(LAT + 4, "R6");
    step(1'b1, 16'hABCD, 16'h4321, "R6");
    step(1'b1, 16'hFFFF, 16'hFFFF, "R6");
    idle(LAT + 2, "R6");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule